// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block owns the chip-wide reset and the output-enable lines that place the pads in or out of the high-impedance state. Three conditions put the chip into reset: an active-low chip-select pin pulled low, a supply-low flag raised by an analog monitor, and loss of the main clock. A free-running watchdog clock detects the lost clock. While any source is active, every output enable is low and every output pad floats.

When all sources clear, the internal reset is released on the main clock. The two clock pads and the serial data pad then re-enable on their own. Every other pad group stays off until software sets its bit in an enable register. An active-low reset indicator stays low through the internal reset and for a fixed count of main-clock cycles after it. Other circuits on the board can use it as their reset. If any source fires during that count, the whole sequence starts again from reset.

Top module: `por_sequencer`

## Requirements
- R1: With `chip_sel_n` low, after its two-stage synchronizer, the block is in reset: `clk_oe`, `sdat_oe` and `grp_oe` are all 0 and `rst_ind_n` is 0.
- R2: With `supply_low` high, after its two-stage synchronizer, the block is in reset in the same way as R1.
- R3: The main clock counts as missing once the watchdog clock sees no main-clock toggle for 8 consecutive watchdog cycles. The block then enters reset without any main-clock edge, so the outputs drop while the clock is stopped. A shorter gap has no effect.
- R4: Internal reset clears the software enable register to 0. The register stays 0 until it is written again.
- R5: After release, `clk_oe` becomes 2'b11 and `sdat_oe` becomes 1 on the first main-clock edge. `grp_oe` stays 0 until software enables a group.
- R6: On a clock edge with `cfg_we` high, `cfg_wdata` is stored in the enable register. On the next edge, `grp_oe[i]` takes bit i of that register. With `cfg_we` low, `cfg_wdata` is ignored.
- R7: `rst_ind_n` is low during internal reset. It rises on the 128th main-clock edge after release, where `clk_oe` rises on the 1st of those edges. It never falls outside reset.
- R8: A reset source that fires while the indicator is still low restarts the sequence. The outputs turn off, the enable register clears, and the full 128-cycle count runs again after the new release.
- R9: Internal reset is asserted asynchronously and released synchronously. It releases two main-clock edges after every synchronized source is clear, so `clk_oe` rises on the 5th main-clock edge after `chip_sel_n` and `supply_low` become inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| wd_clk | input | 1 | Free-running watchdog clock, slower than half the main clock |
| chip_sel_n | input | 1 | Active-low chip select; low forces reset |
| supply_low | input | 1 | Supply-low flag; high forces reset |
| cfg_we | input | 1 | Write strobe for the group enable register |
| cfg_wdata | input | N_GRP | Group enable bits to write |
| clk_oe | output | 2 | Output enables of the two clock pads |
| sdat_oe | output | 1 | Output enable of the serial data pad |
| grp_oe | output | N_GRP | Output enables of the software-controlled pad groups |
| rst_ind_n | output | 1 | Active-low reset indicator for external circuits |

## Verification
The bench stops the main clock and checks the outputs while it is stopped. A design that asserted reset only on a main-clock edge would leave the pads driven at that point. It also compares a short clock gap with a long one, which exposes a miss limit that is off or inverted. The bench counts the indicator and release latencies edge by edge, so an off-by-one in the 128-cycle count or an extra release stage shows up. It also fires a source in the middle of the indicator window and checks that the count restarts and the group enables clear, which catches a design that lets a sequence already running carry on.

// File: rtl/por_pkg.sv
package por_pkg;

  // Progress of the reset-indicator extension after internal reset release.
  typedef enum logic [0:0] {
    IND_COUNT = 1'b0,
    IND_DONE  = 1'b1
  } ind_state_e;

  // Bits needed to hold values 0 .. n-1 (at least one bit).
  function automatic int cnt_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/por_clk_watch.sv
module por_clk_watch #(
  parameter int MISS_LIMIT  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic main_clk,
  input  logic wd_clk,
  input  logic supply_low,
  output logic clk_missing
);
  import por_pkg::*;

  localparam int CW = cnt_bits(MISS_LIMIT);
  localparam logic [CW-1:0] LAST = CW'(MISS_LIMIT - 1);

  // Divide-by-two marker in the main domain; never reset so it keeps
  // toggling while the rest of the chip sits in reset.
  logic tgl = 1'b0;
  always_ff @(posedge main_clk) begin
    tgl <= ~tgl;
  end

  logic tgl_s, sup_w;
  por_sync #(.W(1), .STAGES(SYNC_STAGES)) i_tgl_sync (
    .clk(wd_clk), .d(tgl), .q(tgl_s)
  );
  por_sync #(.W(1), .STAGES(SYNC_STAGES)) i_sup_sync (
    .clk(wd_clk), .d(supply_low), .q(sup_w)
  );

  logic          tgl_d;
  logic          seen;
  logic [CW-1:0] quiet_cnt;

  assign seen = tgl_s ^ tgl_d;

  always_ff @(posedge wd_clk) begin
    tgl_d <= tgl_s;
    if (sup_w) begin
      quiet_cnt   <= '0;
      clk_missing <= 1'b0;
    end else if (seen) begin
      quiet_cnt   <= '0;
      clk_missing <= 1'b0;
    end else if (quiet_cnt == LAST) begin
      clk_missing <= 1'b1;
    end else begin
      quiet_cnt <= quiet_cnt + 1'b1;
    end
  end

  // R3: any observed toggle withdraws the missing-clock report
  a_r3_toggle_clears: assert property (@(posedge wd_clk) disable iff (sup_w)
    seen |=> !clk_missing);

  // R3: the report only appears after a watchdog cycle without a toggle
  a_r3_missing_needs_quiet: assert property (@(posedge wd_clk) disable iff (sup_w)
    $rose(clk_missing) |-> !$past(seen));

endmodule

// File: rtl/por_rst_gen.sv
module por_rst_gen #(
  parameter int IND_CYCLES = 128,
  parameter int REL_STAGES = 2
) (
  input  logic clk,
  input  logic async_req,
  output logic irst,
  output logic rst_ind_n
);
  import por_pkg::*;

  localparam int CW = cnt_bits(IND_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(IND_CYCLES - 1);

  // Asynchronous assertion, synchronous release through a short shift chain.
  logic [REL_STAGES-1:0] rel;

  always_ff @(posedge clk or posedge async_req) begin
    if (async_req) rel <= '1;
    else           rel <= {rel[REL_STAGES-2:0], 1'b0};
  end

  assign irst = rel[REL_STAGES-1];

  ind_state_e    st;
  logic [CW-1:0] ind_cnt;

  always_ff @(posedge clk or posedge irst) begin
    if (irst) begin
      st        <= IND_COUNT;
      ind_cnt   <= '0;
      rst_ind_n <= 1'b0;
    end else if (st == IND_COUNT) begin
      if (ind_cnt == LAST) begin
        st        <= IND_DONE;
        rst_ind_n <= 1'b1;
      end else begin
        ind_cnt <= ind_cnt + 1'b1;
      end
    end
  end

  // R9: release only after the request has been clear for two edges
  a_r9_sync_release: assert property (@(posedge clk) disable iff (async_req)
    $fell(irst) |-> $past(!async_req));

  // R7: the indicator never drops outside internal reset
  a_r7_ind_no_fall: assert property (@(posedge clk) disable iff (irst)
    !$fell(rst_ind_n));

endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int N_GRP       = 4,
  parameter int IND_CYCLES  = 128,
  parameter int MISS_LIMIT  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             wd_clk,
  input  logic             chip_sel_n,
  input  logic             supply_low,
  input  logic             cfg_we,
  input  logic [N_GRP-1:0] cfg_wdata,
  output logic [1:0]       clk_oe,
  output logic             sdat_oe,
  output logic [N_GRP-1:0] grp_oe,
  output logic             rst_ind_n
);

  localparam int N_SRC = 2;

  logic [N_SRC-1:0] src_s;
  logic             ce_req, sup_req, clk_missing, async_req, irst;

  por_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) i_src_sync (
    .clk(clk), .d({~chip_sel_n, supply_low}), .q(src_s)
  );
  assign ce_req  = src_s[1];
  assign sup_req = src_s[0];

  por_clk_watch #(.MISS_LIMIT(MISS_LIMIT), .SYNC_STAGES(SYNC_STAGES)) i_watch (
    .main_clk(clk), .wd_clk(wd_clk), .supply_low(supply_low),
    .clk_missing(clk_missing)
  );

  assign async_req = ce_req | sup_req | clk_missing;

  por_rst_gen #(.IND_CYCLES(IND_CYCLES), .REL_STAGES(2)) i_rst (
    .clk(clk), .async_req(async_req), .irst(irst), .rst_ind_n(rst_ind_n)
  );

  logic [N_GRP-1:0] sw_en;

  always_ff @(posedge clk or posedge irst) begin
    if (irst) begin
      sw_en   <= '0;
      clk_oe  <= '0;
      sdat_oe <= 1'b0;
    end else begin
      clk_oe  <= 2'b11;
      sdat_oe <= 1'b1;
      if (cfg_we) sw_en <= cfg_wdata;
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_ff @(posedge clk or posedge irst) begin
      if (irst) grp_oe[g] <= 1'b0;
      else      grp_oe[g] <= sw_en[g];
    end

    // R6: a group pad drives only after its software bit was set
    a_r6_grp_needs_sw: assert property (@(posedge clk) disable iff (irst)
      grp_oe[g] |-> $past(sw_en[g]));
  end

  // R1: a synchronized chip-select request leaves every pad floating
  a_r1_ce_floats: assert property (@(posedge clk) disable iff (clk_missing)
    ce_req |-> (clk_oe == 2'b00 && !sdat_oe && grp_oe == '0 && !rst_ind_n));

  // R2: a synchronized supply-low request leaves every pad floating
  a_r2_sup_floats: assert property (@(posedge clk) disable iff (clk_missing)
    sup_req |-> (clk_oe == 2'b00 && !sdat_oe && grp_oe == '0 && !rst_ind_n));

  // R5: clock pads and serial data pad come back together
  a_r5_auto_pair: assert property (@(posedge clk) disable iff (irst)
    clk_oe == {2{sdat_oe}});

endmodule

// File: tb/test_por_sequencer.sv
module test_por_sequencer;

  localparam int N_GRP = 4;

  logic             clk = 1'b0;
  logic             wd_clk = 1'b0;
  logic             clk_run = 1'b1;
  logic             chip_sel_n, supply_low, cfg_we;
  logic [N_GRP-1:0] cfg_wdata;
  logic [1:0]       clk_oe;
  logic             sdat_oe;
  logic [N_GRP-1:0] grp_oe;
  logic             rst_ind_n;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2  if (clk_run) clk = ~clk;   // 250 MHz
  always #15 wd_clk = ~wd_clk;          // watchdog clock, 30 ns period

  por_sequencer #(.N_GRP(N_GRP)) i_por_sequencer (
    .clk(clk), .wd_clk(wd_clk), .chip_sel_n(chip_sel_n), .supply_low(supply_low),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .clk_oe(clk_oe), .sdat_oe(sdat_oe),
    .grp_oe(grp_oe), .rst_ind_n(rst_ind_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pads();
    return {24'd0, clk_oe, sdat_oe, grp_oe, rst_ind_n};
  endfunction

  task automatic wait_oe();
    for (int i = 0; i < 60; i++) begin
      if (clk_oe == 2'b11) break;
      @(negedge clk);
    end
  endtask

  // Row: {chip_sel_n, supply_low, we, wdata[3:0], exp_clk_oe[1:0], exp_sdat, exp_grp[3:0]}
  localparam logic [13:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b1, 4'b0101, 2'b11, 1'b1, 4'b0101},  // R6 write
    {1'b1, 1'b0, 1'b1, 4'b1010, 2'b11, 1'b1, 4'b1010},  // R6 overwrite
    {1'b1, 1'b0, 1'b0, 4'b1111, 2'b11, 1'b1, 4'b1010},  // R6 no strobe
    {1'b0, 1'b0, 1'b0, 4'b0000, 2'b00, 1'b0, 4'b0000},  // R1
    {1'b1, 1'b0, 1'b0, 4'b1111, 2'b11, 1'b1, 4'b0000},  // R4/R5 cleared
    {1'b1, 1'b0, 1'b1, 4'b1111, 2'b11, 1'b1, 4'b1111},  // R6
    {1'b1, 1'b1, 1'b0, 4'b0000, 2'b00, 1'b0, 4'b0000},  // R2
    {1'b1, 1'b0, 1'b0, 4'b0110, 2'b11, 1'b1, 4'b0000}   // R4/R5
  };

  initial begin
    chip_sel_n = 1'b0;
    supply_low = 1'b1;
    cfg_we     = 1'b0;
    cfg_wdata  = '0;
    repeat (12) @(negedge clk);
    chk("R1 R2 reset state", pads(), 32'd0);

    // Release and latency
    chip_sel_n = 1'b1;
    supply_low = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 no release after 4 edges", {30'd0, clk_oe}, 32'd0);
    @(negedge clk);
    chk("R9 R5 clock pads on 5th edge", {29'd0, clk_oe, sdat_oe}, 32'h7);
    chk("R5 groups stay off", {28'd0, grp_oe}, 32'd0);
    repeat (126) @(negedge clk);
    chk("R7 indicator low at edge 127", {31'd0, rst_ind_n}, 32'd0);
    @(negedge clk);
    chk("R7 indicator high at edge 128", {31'd0, rst_ind_n}, 32'd1);

    // Table walk
    for (int r = 0; r < 8; r++) begin
      chip_sel_n = VEC[r][13];
      supply_low = VEC[r][12];
      cfg_we     = VEC[r][11];
      cfg_wdata  = VEC[r][10:7];
      @(negedge clk);
      cfg_we = 1'b0;
      repeat (8) @(negedge clk);
      chk($sformatf("R1 R2 R4 R5 R6 vector %0d", r),
          {25'd0, clk_oe, sdat_oe, grp_oe}, {25'd0, VEC[r][6:0]});
    end
    repeat (140) @(negedge clk);
    chk("R7 indicator high after table", {31'd0, rst_ind_n}, 32'd1);

    // R8: restart during the indicator window
    chip_sel_n = 1'b0;
    repeat (4) @(negedge clk);
    chip_sel_n = 1'b1;
    wait_oe();
    repeat (40) @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 4'b1111;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    chk("R8 groups on inside window", {28'd0, grp_oe}, 32'hF);
    supply_low = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 restart turns pads off", pads(), 32'd0);
    supply_low = 1'b0;
    wait_oe();
    chk("R8 R4 enables cleared by restart", {28'd0, grp_oe}, 32'd0);
    repeat (126) @(negedge clk);
    chk("R8 full count again, still low", {31'd0, rst_ind_n}, 32'd0);
    @(negedge clk);
    chk("R8 full count again, high", {31'd0, rst_ind_n}, 32'd1);

    // R3: short gap is ignored
    cfg_we = 1'b1; cfg_wdata = 4'b0011;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (4) @(negedge clk);
    clk_run = 1'b0;
    #90;
    clk_run = 1'b1;
    repeat (30) @(negedge clk);
    chk("R3 short gap ignored", pads(), {24'd0, 2'b11, 1'b1, 4'b0011, 1'b1});

    // R3: long gap resets without clock edges
    clk_run = 1'b0;
    #500;
    chk("R3 pads off while clock stopped", pads(), 32'd0);
    clk_run = 1'b1;
    repeat (60) @(negedge clk);
    chk("R3 R5 recovered after clock returns", {25'd0, clk_oe, sdat_oe, grp_oe},
        {25'd0, 2'b11, 1'b1, 4'b0000});
    chk("R3 R7 indicator still counting", {31'd0, rst_ind_n}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule